// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache Lookup

This block is the lookup stage of a read-only data cache. Its set index and line offset come only from the untranslated low twelve bits of a 24-bit virtual address, the page offset of a 4 KB page. All sixteen ways of the selected set are read in the same cycle that an eight-entry, fully associative translation buffer maps the upper twelve bits (the virtual page number) to a physical page number. Each way holds a 64-byte line and, as its tag, the physical page number of the line. A hit needs a successful translation and a valid way whose stored tag equals the translated page number. The cache holds 64 KB in 64 sets of 16 ways.

Because the index never uses translated bits, every virtual alias of one physical line selects the same set, and the physical tag compare finds the line whichever alias is used. The surrounding logic loads translations by entry number through a write port. It loads whole lines with their physical tag through a fill port. The fill lands in the way named by a round-robin pointer kept for each set.

Requests use a valid/ready pair. The lookup arrays have one port, so `req_ready` is low in any cycle in which `fill_en` is high. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. The response has no back-pressure: `resp_valid` pulses for exactly one cycle.

Top module: `vipt_lookup`

## Requirements
- R1: `resp_valid` is high in the cycle after an accepted request, and low in every other cycle.
- R2: When the translation succeeds and a valid way of set `vaddr[11:6]` holds a tag equal to the translated page number, the response has `resp_hit`=1 and `resp_tlb_miss`=0. `resp_data` is then word `vaddr[5:2]` of that line, where word w is line bits [32w+31:32w].
- R3: When no valid translation entry holds the page number `vaddr[23:12]`, the response has `resp_tlb_miss`=1, `resp_hit`=0 and `resp_data`=0, even if a line with a matching tag is present.
- R4: Two virtual pages that translate to the same physical page hit the same stored line and return the same words.
- R5: A line whose stored tag differs from the translated page number does not hit, even when it sits in the indexed set.
- R6: Fills to a set go to ways 0, 1, 2 and so on up to 15, then wrap to way 0. The seventeenth fill to a set therefore replaces the first line filled there, and leaves the other fifteen lines in place.
- R7: While `fill_en` is high, `req_ready` is low and a request presented in that cycle is not taken, so no response follows it.
- R8: A translation write replaces the entry selected by `tlb_wr_idx`. Writing it with `tlb_wr_valid`=0 removes that translation, so later requests to that page report `resp_tlb_miss`=1.
- R9: After reset all lines are invalid, all translations are invalid, every round-robin pointer is 0, `resp_valid` is 0 and `req_ready` is 1.
- R10: When the translation succeeds but no way matches, the response has `resp_hit`=0, `resp_tlb_miss`=0 and `resp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be taken (low during a fill) |
| req_vaddr | input | 24 | Virtual byte address |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Physical tag match in a valid way |
| resp_tlb_miss | output | 1 | No translation for the page |
| resp_data | output | 32 | Selected word on a hit, else 0 |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_idx | input | 3 | Entry number to write |
| tlb_wr_valid | input | 1 | Valid bit written to the entry |
| tlb_wr_vpn | input | 12 | Virtual page number for the entry |
| tlb_wr_ppn | input | 12 | Physical page number for the entry |
| fill_en | input | 1 | Write one line into the cache |
| fill_set | input | 6 | Set receiving the line |
| fill_ppn | input | 12 | Physical tag for the line |
| fill_line | input | 512 | Line contents, word 0 in the low bits |

## Verification
The only timed result is the response. Translation and array reads are registered together, so hit, translation miss and data are all due in the cycle after the edge that takes the request. The bench drives a request at a falling edge and reads all three outputs at the next falling edge, half a cycle after that capture edge. Translation and fill writes take effect at the rising edge after they are driven, so each check is made only after the write it depends on has completed. A refused request during a fill is checked one cycle later for the absence of `resp_valid`.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned VA_W_D       = 24;
  localparam int unsigned PAGE_OFF_W_D = 12;
  localparam int unsigned PPN_W_D      = 12;
  localparam int unsigned WAYS_D       = 16;
  localparam int unsigned LINE_BYTES_D = 64;
  localparam int unsigned DATA_W_D     = 32;
  localparam int unsigned TLB_N_D      = 8;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 12,
  parameter int unsigned PPN_W   = 12,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic             ent_v   [ENTRIES];
  logic [VPN_W-1:0] ent_vpn [ENTRIES];
  logic [PPN_W-1:0] ent_ppn [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i]   <= 1'b0;
        ent_vpn[i] <= '0;
        ent_ppn[i] <= '0;
      end
    end else if (wr_en) begin
      ent_v[wr_idx]   <= wr_valid;
      ent_vpn[wr_idx] <= wr_vpn;
      ent_ppn[wr_idx] <= wr_ppn;
    end
  end

  // lowest matching entry wins if software ever loads a duplicate
  always_comb begin
    look_hit = 1'b0;
    look_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!look_hit && ent_v[i] && ent_vpn[i] == look_vpn) begin
        look_hit = 1'b1;
        look_ppn = ent_ppn[i];
      end
    end
  end

  assert_tlb_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_v[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int unsigned SETS      = 64,
  parameter int unsigned TAG_W     = 12,
  parameter int unsigned LINE_BITS = 512,
  localparam int unsigned SET_W    = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [SET_W-1:0]     rd_set,
  output logic                 rd_valid,
  output logic [TAG_W-1:0]     rd_tag,
  output logic [LINE_BITS-1:0] rd_line,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [LINE_BITS-1:0] wr_line
);
  logic                 valid_q [SETS];
  logic [TAG_W-1:0]     tag_q   [SETS];
  logic [LINE_BITS-1:0] line_q  [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_set] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_set];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      line_q[wr_set] <= wr_line;
    end
    if (rd_en) begin
      rd_tag  <= tag_q[rd_set];
      rd_line <= line_q[rd_set];
    end
  end

  assert_way_fill_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_set)]);
endmodule

// File: rtl/vipt_rr_victim.sv
module vipt_rr_victim #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 16,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SET_W-1:0] set_idx,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];

  assign victim = ptr_q[set_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      ptr_q[set_idx] <= (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;
    end
  end

  assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q[$past(set_idx)] ==
             (($past(victim) == WAY_W'(WAYS - 1)) ? '0 : $past(victim) + 1'b1)));
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W       = VA_W_D,
  parameter int unsigned PAGE_OFF_W = PAGE_OFF_W_D,
  parameter int unsigned PPN_W      = PPN_W_D,
  parameter int unsigned WAYS       = WAYS_D,
  parameter int unsigned LINE_BYTES = LINE_BYTES_D,
  parameter int unsigned DATA_W     = DATA_W_D,
  parameter int unsigned TLB_N      = TLB_N_D,
  localparam int unsigned VPN_W     = VA_W - PAGE_OFF_W,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned SET_W     = PAGE_OFF_W - OFF_W,
  localparam int unsigned SETS      = 1 << SET_W,
  localparam int unsigned LINE_BITS = LINE_BYTES * 8,
  localparam int unsigned WORDS     = LINE_BITS / DATA_W,
  localparam int unsigned WSEL_W    = $clog2(WORDS),
  localparam int unsigned BYTE_W    = OFF_W - WSEL_W,
  localparam int unsigned TIDX_W    = $clog2(TLB_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic                 resp_tlb_miss,
  output logic [DATA_W-1:0]    resp_data,
  input  logic                 tlb_wr_en,
  input  logic [TIDX_W-1:0]    tlb_wr_idx,
  input  logic                 tlb_wr_valid,
  input  logic [VPN_W-1:0]     tlb_wr_vpn,
  input  logic [PPN_W-1:0]     tlb_wr_ppn,
  input  logic                 fill_en,
  input  logic [SET_W-1:0]     fill_set,
  input  logic [PPN_W-1:0]     fill_ppn,
  input  logic [LINE_BITS-1:0] fill_line
);
  localparam int unsigned WAY_W = $clog2(WAYS);

  // request decode: the index comes from page-offset bits only
  logic              take;
  logic [VPN_W-1:0]  req_vpn;
  logic [SET_W-1:0]  req_set;
  logic [WSEL_W-1:0] req_word;
  logic              unused_byte;

  assign req_ready   = !fill_en;
  assign take        = req_valid && req_ready;
  assign req_vpn     = req_vaddr[VA_W-1:PAGE_OFF_W];
  assign req_set     = req_vaddr[PAGE_OFF_W-1:OFF_W];
  assign req_word    = req_vaddr[OFF_W-1:BYTE_W];
  assign unused_byte = ^req_vaddr[BYTE_W-1:0];

  // translation in parallel with the array read
  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;

  vipt_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_vpn (req_vpn),
    .look_hit (tlb_hit),
    .look_ppn (tlb_ppn),
    .wr_en    (tlb_wr_en),
    .wr_idx   (tlb_wr_idx),
    .wr_valid (tlb_wr_valid),
    .wr_vpn   (tlb_wr_vpn),
    .wr_ppn   (tlb_wr_ppn)
  );

  // replacement choice for fills
  logic [WAY_W-1:0] victim;

  vipt_rr_victim #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (fill_en),
    .set_idx (fill_set),
    .victim  (victim)
  );

  // ways
  logic                 way_v    [WAYS];
  logic [PPN_W-1:0]     way_tag  [WAYS];
  logic [LINE_BITS-1:0] way_line [WAYS];
  logic [WAYS-1:0]      way_match;

  // registered request context, aligned with the array read data
  logic              rv_q;
  logic              thit_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [WSEL_W-1:0] word_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way #(.SETS(SETS), .TAG_W(PPN_W), .LINE_BITS(LINE_BITS)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (take),
      .rd_set   (req_set),
      .rd_valid (way_v[w]),
      .rd_tag   (way_tag[w]),
      .rd_line  (way_line[w]),
      .wr_en    (fill_en && victim == WAY_W'(w)),
      .wr_set   (fill_set),
      .wr_tag   (fill_ppn),
      .wr_line  (fill_line)
    );
    assign way_match[w] = way_v[w] && (way_tag[w] == ppn_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      thit_q <= 1'b0;
      ppn_q  <= '0;
      word_q <= '0;
    end else begin
      rv_q <= take;
      if (take) begin
        thit_q <= tlb_hit;
        ppn_q  <= tlb_ppn;
        word_q <= req_word;
      end
    end
  end

  // physical tag compare and word select
  logic                 any_match;
  logic [LINE_BITS-1:0] sel_line;

  always_comb begin
    any_match = 1'b0;
    sel_line  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_match && way_match[w]) begin
        any_match = 1'b1;
        sel_line  = way_line[w];
      end
    end
  end

  assign resp_valid    = rv_q;
  assign resp_tlb_miss = rv_q && !thit_q;
  assign resp_hit      = rv_q && thit_q && any_match;
  assign resp_data     = resp_hit ? sel_line[word_q*DATA_W +: DATA_W] : '0;

  assert_resp_follows_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));
  assert_hit_has_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (resp_valid && !resp_tlb_miss));
  assert_miss_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_tlb_miss |-> (!resp_hit && resp_data == '0));
  assert_fill_blocks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !resp_valid);
endmodule

// File: tb/vipt_lookup_tb.sv
`timescale 1ns/1ps
module vipt_lookup_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [23:0]  req_vaddr = '0;
  logic         resp_valid, resp_hit, resp_tlb_miss;
  logic [31:0]  resp_data;
  logic         tlb_wr_en = 1'b0;
  logic [2:0]   tlb_wr_idx = '0;
  logic         tlb_wr_valid = 1'b0;
  logic [11:0]  tlb_wr_vpn = '0;
  logic [11:0]  tlb_wr_ppn = '0;
  logic         fill_en = 1'b0;
  logic [5:0]   fill_set = '0;
  logic [11:0]  fill_ppn = '0;
  logic [511:0] fill_line = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  vipt_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_tlb_miss(resp_tlb_miss),
    .resp_data(resp_data),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_idx(tlb_wr_idx), .tlb_wr_valid(tlb_wr_valid),
    .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
    .fill_en(fill_en), .fill_set(fill_set), .fill_ppn(fill_ppn), .fill_line(fill_line)
  );

  function automatic logic [31:0] word_of(input logic [11:0] ppn, input logic [5:0] set,
                                          input logic [3:0] w);
    return {4'hA, ppn, 2'b00, set, 4'h0, w};
  endfunction

  function automatic logic [511:0] line_of(input logic [11:0] ppn, input logic [5:0] set);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = word_of(ppn, set, 4'(w));
    return l;
  endfunction

  function automatic logic [23:0] va(input logic [11:0] vpn, input logic [5:0] set,
                                     input logic [3:0] w);
    return {vpn, set, w, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tlb_put(input logic [2:0] idx, input logic v, input logic [11:0] vpn,
                         input logic [11:0] ppn);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_idx = idx; tlb_wr_valid = v;
    tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
    @(negedge clk);
    tlb_wr_en = 1'b0;
  endtask

  task automatic fill(input logic [5:0] set, input logic [11:0] ppn);
    @(negedge clk);
    fill_en = 1'b1; fill_set = set; fill_ppn = ppn; fill_line = line_of(ppn, set);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // drive at a falling edge, taken at the rising edge, sampled at the next falling edge
  task automatic lookup(input logic [23:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_resp(input string req, input logic h, input logic m,
                             input logic [31:0] d);
    chk({req, " valid"}, 512'(resp_valid), 512'(1'b1));
    chk({req, " hit"},   512'(resp_hit), 512'(h));
    chk({req, " tlbmiss"}, 512'(resp_tlb_miss), 512'(m));
    chk({req, " data"},  512'(resp_data), 512'(d));
  endtask

  // {vaddr[23:0], exp_hit, exp_tlb_miss, exp_ppn[11:0]}
  localparam logic [37:0] VEC [6] = '{
    {12'h010, 6'd5, 4'd3,  2'b00, 1'b1, 1'b0, 12'h0A5},  // R2 direct hit
    {12'h020, 6'd5, 4'd7,  2'b00, 1'b1, 1'b0, 12'h0A5},  // R4 alias page
    {12'h030, 6'd5, 4'd0,  2'b00, 1'b0, 1'b0, 12'h0B7},  // R5 wrong physical tag
    {12'h030, 6'd9, 4'd15, 2'b00, 1'b1, 1'b0, 12'h0B7},  // R2 last word
    {12'h040, 6'd5, 4'd3,  2'b00, 1'b0, 1'b1, 12'h000},  // R3 no translation
    {12'h010, 6'd9, 4'd0,  2'b00, 1'b0, 1'b0, 12'h0A5}   // R10 set holds other page
  };

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 resp_valid in reset", 512'(resp_valid), 512'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 req_ready after reset", 512'(req_ready), 512'(1'b1));
    chk("R1 idle no response", 512'(resp_valid), 512'(1'b0));

    tlb_put(3'd0, 1'b1, 12'h010, 12'h0A5);
    lookup(va(12'h010, 6'd5, 4'd3));
    expect_resp("R9 lines invalid after reset", 1'b0, 1'b0, 32'h0);
    lookup(va(12'h020, 6'd5, 4'd3));
    expect_resp("R9 tlb empty after reset", 1'b0, 1'b1, 32'h0);

    tlb_put(3'd1, 1'b1, 12'h020, 12'h0A5);
    tlb_put(3'd2, 1'b1, 12'h030, 12'h0B7);
    fill(6'd5, 12'h0A5);
    fill(6'd9, 12'h0B7);

    for (int i = 0; i < 6; i++) begin
      logic [23:0] a;
      a = VEC[i][37:14];
      lookup(a);
      expect_resp($sformatf("R2/R3/R4/R5/R10 vector %0d", i), VEC[i][13], VEC[i][12],
                  VEC[i][13] ? word_of(VEC[i][11:0], a[11:6], a[5:2]) : 32'h0);
    end
    @(negedge clk);
    chk("R1 no response without request", 512'(resp_valid), 512'(1'b0));

    // R7: request during a fill is refused
    @(negedge clk);
    fill_en = 1'b1; fill_set = 6'd40; fill_ppn = 12'h0C1; fill_line = line_of(12'h0C1, 6'd40);
    req_valid = 1'b1; req_vaddr = va(12'h010, 6'd5, 4'd1);
    #0.5;
    chk("R7 req_ready low during fill", 512'(req_ready), 512'(1'b0));
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    chk("R7 refused request gives no response", 512'(resp_valid), 512'(1'b0));

    // R6: round robin over 16 ways, 17th fill evicts the first
    tlb_put(3'd3, 1'b1, 12'h050, 12'h100);
    tlb_put(3'd4, 1'b1, 12'h051, 12'h101);
    tlb_put(3'd5, 1'b1, 12'h052, 12'h110);
    tlb_put(3'd6, 1'b1, 12'h053, 12'h10F);
    for (int k = 0; k < 16; k++) fill(6'd20, 12'h100 + 12'(k));
    lookup(va(12'h050, 6'd20, 4'd2));
    expect_resp("R6 first fill present", 1'b1, 1'b0, word_of(12'h100, 6'd20, 4'd2));
    lookup(va(12'h053, 6'd20, 4'd4));
    expect_resp("R6 sixteenth fill present", 1'b1, 1'b0, word_of(12'h10F, 6'd20, 4'd4));
    fill(6'd20, 12'h110);
    lookup(va(12'h050, 6'd20, 4'd2));
    expect_resp("R6 seventeenth fill evicts first", 1'b0, 1'b0, 32'h0);
    lookup(va(12'h051, 6'd20, 4'd6));
    expect_resp("R6 second fill kept", 1'b1, 1'b0, word_of(12'h101, 6'd20, 4'd6));
    lookup(va(12'h052, 6'd20, 4'd9));
    expect_resp("R6 new line present", 1'b1, 1'b0, word_of(12'h110, 6'd20, 4'd9));
    lookup(va(12'h030, 6'd5, 4'd0));
    expect_resp("R6 other set untouched (R5)", 1'b0, 1'b0, 32'h0);

    // R8: invalidate then remap an entry
    tlb_put(3'd0, 1'b0, 12'h010, 12'h0A5);
    lookup(va(12'h010, 6'd5, 4'd3));
    expect_resp("R8 invalidated entry", 1'b0, 1'b1, 32'h0);
    tlb_put(3'd0, 1'b1, 12'h010, 12'h0B7);
    lookup(va(12'h010, 6'd9, 4'd11));
    expect_resp("R8 remapped entry", 1'b1, 1'b0, word_of(12'h0B7, 6'd9, 4'd11));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule